// File: doc/BRIEF.md
# Mel Filterbank Log-Energy Accumulator

This block sits between a frequency transform and a cosine transform in a speech feature pipeline. It takes one frame of unsigned power-spectrum bins, lowest frequency first, through a valid/ready stream. It weights each bin by a triangular filter response and folds the results into a set of band accumulators. The filters are spaced so that bands are narrow at low frequency and widen towards high frequency. Adjacent triangles overlap by half, so each bin adds to at most two neighbouring bands, with weights that sum to one.

When the last bin of the frame has been taken, the block converts every band energy to an approximate base-2 logarithm. It then streams the results out in band order and marks the final word. The input side stays closed until the whole result vector has been handed off. A frame is a fixed count of accepted bins, so the producer needs no frame marker.

Top module: `mel_logbank`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: The edge points are e[k] = EDGE0 + k*EDGE_STEP + floor(S*k*k/(NUM_FILT+1)^2) for k = 0..NUM_FILT+1, where S = NUM_BINS-1-EDGE0-(NUM_FILT+1)*EDGE_STEP. With the defaults (1, 2, 256 bins, 20 bands) this gives e[0]=1 and e[21]=255, and the gap between points widens with k.
- R3: Consider a bin of index b and value x with e[i] <= b < e[i+1]. Its rising weight is w = floor((b-e[i])*65536/(e[i+1]-e[i])). It adds floor(x*w/65536) to band i when i < NUM_FILT, and floor(x*(65536-w)/65536) to band i-1 when i >= 1. A bin below e[0], or at or above e[NUM_FILT+1], adds nothing.
- R4: A frame is NUM_BINS consecutive accepted bins, with bin index 0 first. Every band accumulator restarts from zero at bin 0 of each frame, so nothing carries over from an earlier frame.
- R5: Each output word is an unsigned Q6.8 value. Bits 13:8 hold the position p of the leading one of the band energy. Bits 7:0 hold the 8 energy bits just below that leading one, zero-filled when p < 8.
- R6: A band energy of zero is emitted as 0.
- R7: After the last bin of a frame is accepted, exactly NUM_FILT words are emitted, band 0 first. out_last is 1 on the final word only. After that final handshake, in_ready is 1 and out_valid is 0.
- R8: in_ready stays 0 from the acceptance of the last bin until the final output handshake. Bins presented during that time are ignored and leave the results unchanged.
- R9: While out_valid is 1 and out_ready is 0, out_loge and out_last stay unchanged in the next cycle.
- R10: A frame of all-ones bins (the largest value on every bin) produces the correct results without the 48-bit band accumulators wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A spectrum bin is offered |
| in_ready | output | 1 | The block takes a bin this cycle |
| in_bin | input | 32 | Unsigned power value of the current bin |
| out_valid | output | 1 | A band log-energy word is offered |
| out_ready | input | 1 | The consumer takes the word this cycle |
| out_loge | output | 14 | Band log-energy, unsigned Q6.8 |
| out_last | output | 1 | Marks the final band of the frame |

## Verification
The embedded assertions watch, on every cycle, the protocol-level behaviour. The input stays closed while results are offered, and a stalled output word holds its value. The handshake on the final word reopens the input. No band accumulator carries out of its 48 bits, and the integer part of each logarithm points at the leading one of the energy it was taken from. The exact numbers can only be shown by the bench scenarios, which compute the expected values arithmetically. These are the edge table, the split of each bin between two neighbouring bands, the clearing between frames and the fractional log bits. The scenarios include an impulse at every bin position, all-zero and all-ones frames, and ramp and pseudo-random spectra, run under input gaps and output back-pressure.

// File: rtl/mel_pkg.sv
package mel_pkg;

   typedef enum logic [1:0] {
      ST_COLLECT = 2'd0,
      ST_SETTLE  = 2'd1,
      ST_EMIT    = 2'd2
   } mel_state_e;

   // Edge point k of the triangle chain: linear term plus a quadratic stretch
   function automatic int band_edge(input int k, input int nbins, input int nfilt,
                                    input int e0, input int step);
      int top_k;
      int stretch;
      top_k   = nfilt + 1;
      stretch = nbins - 1 - e0 - top_k * step;
      return e0 + k * step + (stretch * k * k) / (top_k * top_k);
   endfunction

   // Segment holding bin b, or -1 when the bin lies outside every triangle
   function automatic int bin_segment(input int b, input int nbins, input int nfilt,
                                      input int e0, input int step);
      int found;
      found = -1;
      for (int k = 0; k <= nfilt; k++) begin
         if (b >= band_edge(k, nbins, nfilt, e0, step) &&
             b <  band_edge(k + 1, nbins, nfilt, e0, step))
            found = k;
      end
      return found;
   endfunction

   // Rising weight of bin b inside its segment, scaled by 2**wt_w
   function automatic int bin_rise(input int b, input int wt_w, input int nbins,
                                   input int nfilt, input int e0, input int step);
      int k;
      int lo;
      int hi;
      k = bin_segment(b, nbins, nfilt, e0, step);
      if (k < 0) return 0;
      lo = band_edge(k, nbins, nfilt, e0, step);
      hi = band_edge(k + 1, nbins, nfilt, e0, step);
      return ((b - lo) << wt_w) / (hi - lo);
   endfunction

endpackage

// File: rtl/mel_coef_rom.sv
module mel_coef_rom #(
   parameter int NUM_BINS  = 256,
   parameter int NUM_FILT  = 20,
   parameter int WT_W      = 16,
   parameter int EDGE0     = 1,
   parameter int EDGE_STEP = 2,
   localparam int IDX_W    = $clog2(NUM_BINS),
   localparam int SEG_W    = $clog2(NUM_FILT + 1)
) (
   input  logic [IDX_W-1:0] bin_idx,
   output logic [SEG_W-1:0] seg,
   output logic [WT_W-1:0]  rise,
   output logic             hit
);

   logic [SEG_W-1:0] seg_tbl  [NUM_BINS];
   logic [WT_W-1:0]  rise_tbl [NUM_BINS];
   logic             hit_tbl  [NUM_BINS];

   // Table contents are computed at elaboration from the edge formula
   for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
      localparam int SEG_I  = mel_pkg::bin_segment(b, NUM_BINS, NUM_FILT, EDGE0, EDGE_STEP);
      localparam int SEG_C  = (SEG_I < 0) ? 0 : SEG_I;
      localparam int RISE_I = mel_pkg::bin_rise(b, WT_W, NUM_BINS, NUM_FILT, EDGE0, EDGE_STEP);
      assign seg_tbl[b]  = SEG_W'(SEG_C);
      assign rise_tbl[b] = WT_W'(RISE_I);
      assign hit_tbl[b]  = (SEG_I >= 0) ? 1'b1 : 1'b0;
   end

   assign seg  = seg_tbl[bin_idx];
   assign rise = rise_tbl[bin_idx];
   assign hit  = hit_tbl[bin_idx];

endmodule

// File: rtl/mel_weight_stage.sv
module mel_weight_stage #(
   parameter int BIN_W = 32,
   parameter int WT_W  = 16,
   parameter int SEG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             first,
   input  logic [BIN_W-1:0] data,
   input  logic [SEG_W-1:0] seg,
   input  logic [WT_W-1:0]  rise,
   input  logic             hit,
   output logic             s_valid,
   output logic             s_clr,
   output logic [SEG_W-1:0] s_seg,
   output logic             s_hit,
   output logic [BIN_W-1:0] s_up,
   output logic [BIN_W-1:0] s_dn
);

   localparam int PW = BIN_W + WT_W + 1;
   localparam logic [WT_W:0] UNITY = {1'b1, {WT_W{1'b0}}};

   logic [WT_W:0]  fall;
   logic [PW-1:0]  up_prod;
   logic [PW-1:0]  dn_prod;
   logic [BIN_W-1:0] up_val;
   logic [BIN_W-1:0] dn_val;

   // Complementary weights: the lower band takes one minus the rising weight
   always_comb begin
      fall    = UNITY - {1'b0, rise};
      up_prod = PW'(data) * PW'(rise);
      dn_prod = PW'(data) * PW'(fall);
      up_val  = BIN_W'(up_prod >> WT_W);
      dn_val  = BIN_W'(dn_prod >> WT_W);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_valid <= 1'b0;
         s_clr   <= 1'b0;
         s_seg   <= '0;
         s_hit   <= 1'b0;
         s_up    <= '0;
         s_dn    <= '0;
      end else begin
         s_valid <= take;
         if (take) begin
            s_clr <= first;
            s_seg <= seg;
            s_hit <= hit;
            s_up  <= up_val;
            s_dn  <= dn_val;
         end
      end
   end

endmodule

// File: rtl/mel_band_acc.sv
module mel_band_acc #(
   parameter int NUM_FILT = 20,
   parameter int BIN_W    = 32,
   parameter int ACC_W    = 48,
   parameter int SEG_W    = 5,
   localparam int FILT_W  = $clog2(NUM_FILT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic              s_clr,
   input  logic [SEG_W-1:0]  s_seg,
   input  logic              s_hit,
   input  logic [BIN_W-1:0]  s_up,
   input  logic [BIN_W-1:0]  s_dn,
   input  logic [FILT_W-1:0] rd_idx,
   output logic [ACC_W-1:0]  rd_energy
);

   logic [ACC_W-1:0] acc [NUM_FILT];

   for (genvar j = 0; j < NUM_FILT; j++) begin : g_band
      logic [ACC_W-1:0] add;
      logic [ACC_W-1:0] base;
      logic [ACC_W:0]   nxt;

      always_comb begin
         add = '0;
         // Band j rises in segment j and falls in segment j+1
         if (s_hit && s_seg == SEG_W'(j))     add = add + ACC_W'(s_up);
         if (s_hit && s_seg == SEG_W'(j + 1)) add = add + ACC_W'(s_dn);
         base = s_clr ? '0 : acc[j];
         nxt  = {1'b0, base} + {1'b0, add};
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       acc[j] <= '0;
         else if (s_valid) acc[j] <= nxt[ACC_W-1:0];
      end

      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         s_valid |-> !nxt[ACC_W]); // R10
   end

   assign rd_energy = acc[rd_idx];

endmodule

// File: rtl/mel_log2.sv
module mel_log2 #(
   parameter int ACC_W  = 48,
   parameter int FRAC_W = 8,
   localparam int INT_W = $clog2(ACC_W),
   localparam int OUT_W = INT_W + FRAC_W
) (
   input  logic [ACC_W-1:0] energy,
   output logic [OUT_W-1:0] loge
);

   logic [INT_W-1:0] lead;
   logic [ACC_W-1:0] norm;
   logic [FRAC_W-1:0] frac;

   always_comb begin
      lead = '0;
      for (int i = 0; i < ACC_W; i++) begin
         if (energy[i]) lead = INT_W'(i);
      end
      // Move the leading one to the top; the bits under it form the fraction
      norm = energy << (INT_W'(ACC_W - 1) - lead);
      frac = FRAC_W'(norm >> (ACC_W - 1 - FRAC_W));
      loge = (energy == '0) ? '0 : {lead, frac};
   end

   always_comb begin
      if (energy != '0) begin
         AST_LOG_LEAD: assert ((energy >> loge[OUT_W-1:FRAC_W]) == ACC_W'(1)); // R5
      end
   end

endmodule

// File: rtl/mel_logbank.sv
module mel_logbank #(
   parameter int NUM_BINS  = 256,
   parameter int BIN_W     = 32,
   parameter int NUM_FILT  = 20,
   parameter int ACC_W     = 48,
   parameter int WT_W      = 16,
   parameter int FRAC_W    = 8,
   parameter int EDGE0     = 1,
   parameter int EDGE_STEP = 2,
   localparam int OUT_W    = $clog2(ACC_W) + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [BIN_W-1:0] in_bin,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [OUT_W-1:0] out_loge,
   output logic             out_last
);

   import mel_pkg::*;

   localparam int IDX_W  = $clog2(NUM_BINS);
   localparam int FILT_W = $clog2(NUM_FILT);
   localparam int SEG_W  = $clog2(NUM_FILT + 1);
   localparam int SPAN   = NUM_BINS - 1 - EDGE0 - (NUM_FILT + 1) * EDGE_STEP;

   // Elaboration-time parameter checks
   if (NUM_FILT < 2) begin : g_bad_filt
      $error("mel_logbank: at least two bands are needed");
   end
   if (EDGE_STEP < 1 || SPAN < 0) begin : g_bad_edges
      $error("mel_logbank: edge points do not fit inside the bin range");
   end
   if (ACC_W < BIN_W + IDX_W || ACC_W - 1 <= FRAC_W) begin : g_bad_acc
      $error("mel_logbank: accumulator too narrow");
   end
   if (WT_W < 2) begin : g_bad_wt
      $error("mel_logbank: weight width too small");
   end

   mel_state_e state;
   logic [IDX_W-1:0]  bin_cnt;
   logic [FILT_W-1:0] band_cnt;
   logic take;
   logic bin_last;
   logic band_last;

   logic [SEG_W-1:0] rom_seg;
   logic [WT_W-1:0]  rom_rise;
   logic             rom_hit;

   logic             s_valid;
   logic             s_clr;
   logic [SEG_W-1:0] s_seg;
   logic             s_hit;
   logic [BIN_W-1:0] s_up;
   logic [BIN_W-1:0] s_dn;
   logic [ACC_W-1:0] band_energy;

   assign in_ready  = (state == ST_COLLECT);
   assign take      = in_valid && in_ready;
   assign bin_last  = (bin_cnt == IDX_W'(NUM_BINS - 1));
   assign band_last = (band_cnt == FILT_W'(NUM_FILT - 1));
   assign out_valid = (state == ST_EMIT);
   assign out_last  = out_valid && band_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_COLLECT;
         bin_cnt  <= '0;
         band_cnt <= '0;
      end else begin
         unique case (state)
            ST_COLLECT: begin
               if (take) begin
                  if (bin_last) begin
                     bin_cnt <= '0;
                     state   <= ST_SETTLE;
                  end else begin
                     bin_cnt <= bin_cnt + 1'b1;
                  end
               end
            end
            ST_SETTLE: begin
               // Last weighted bin lands in the accumulators here
               band_cnt <= '0;
               state    <= ST_EMIT;
            end
            ST_EMIT: begin
               if (out_ready) begin
                  if (band_last) begin
                     band_cnt <= '0;
                     state    <= ST_COLLECT;
                  end else begin
                     band_cnt <= band_cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_COLLECT;
         endcase
      end
   end

   mel_coef_rom #(
      .NUM_BINS (NUM_BINS),
      .NUM_FILT (NUM_FILT),
      .WT_W     (WT_W),
      .EDGE0    (EDGE0),
      .EDGE_STEP(EDGE_STEP)
   ) rom_i (
      .bin_idx(bin_cnt),
      .seg    (rom_seg),
      .rise   (rom_rise),
      .hit    (rom_hit)
   );

   mel_weight_stage #(
      .BIN_W(BIN_W),
      .WT_W (WT_W),
      .SEG_W(SEG_W)
   ) wgt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .first  (bin_cnt == '0),
      .data   (in_bin),
      .seg    (rom_seg),
      .rise   (rom_rise),
      .hit    (rom_hit),
      .s_valid(s_valid),
      .s_clr  (s_clr),
      .s_seg  (s_seg),
      .s_hit  (s_hit),
      .s_up   (s_up),
      .s_dn   (s_dn)
   );

   mel_band_acc #(
      .NUM_FILT(NUM_FILT),
      .BIN_W   (BIN_W),
      .ACC_W   (ACC_W),
      .SEG_W   (SEG_W)
   ) acc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_valid  (s_valid),
      .s_clr    (s_clr),
      .s_seg    (s_seg),
      .s_hit    (s_hit),
      .s_up     (s_up),
      .s_dn     (s_dn),
      .rd_idx   (band_cnt),
      .rd_energy(band_energy)
   );

   mel_log2 #(
      .ACC_W (ACC_W),
      .FRAC_W(FRAC_W)
   ) log_i (
      .energy(band_energy),
      .loge  (out_loge)
   );

   AST_INPUT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready); // R8

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_loge) && $stable(out_last))); // R9

   AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (in_ready && !out_valid)); // R7

endmodule

// File: tb/mel_logbank_tb_top.sv
module mel_logbank_tb_top;

   localparam int NB    = 256;
   localparam int NF    = 20;
   localparam int E0    = 1;
   localparam int STEP  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_bin = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [13:0] out_loge;
   logic        out_last;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   logic [31:0] frame [NB];
   longint      exp_log [NF];
   int unsigned lfsr = 32'h1ACE_B00C;

   always #10 clk = ~clk;

   mel_logbank dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_bin   (in_bin),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_loge (out_loge),
      .out_last (out_last)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic longint edge_at(input int k);
      longint span;
      span = NB - 1 - E0 - (NF + 1) * STEP;
      return E0 + k * STEP + (span * k * k) / ((NF + 1) * (NF + 1));
   endfunction

   function automatic longint log_q68(input longint e);
      int p;
      longint f;
      if (e == 0) return 0;
      p = 0;
      for (int i = 0; i < 48; i++) if (e[i]) p = i;
      if (p >= 8) f = (e >> (p - 8)) & 255;
      else        f = (e << (8 - p)) & 255;
      return longint'(p) * 256 + f;
   endfunction

   task automatic build_expected();
      longint en [NF];
      for (int j = 0; j < NF; j++) en[j] = 0;
      for (int b = 0; b < NB; b++) begin
         for (int i = 0; i <= NF; i++) begin
            longint lo;
            longint hi;
            longint w;
            longint x;
            lo = edge_at(i);
            hi = edge_at(i + 1);
            if (b >= lo && b < hi) begin
               x = longint'(frame[b]);
               w = ((b - lo) * 65536) / (hi - lo);
               if (i < NF)  en[i]     += (x * w) >> 16;
               if (i >= 1)  en[i - 1] += (x * (65536 - w)) >> 16;
            end
         end
      end
      for (int j = 0; j < NF; j++) exp_log[j] = log_q68(en[j]);
   endtask

   // Feed one frame, then collect and compare the band words
   task automatic run_frame(input bit gaps, input bit backpressure, input string req);
      int k;
      bit   held;
      logic [13:0] held_val;
      build_expected();
      for (int b = 0; b < NB; b++) begin
         if (gaps && ($urandom % 5 == 0)) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_bin   = frame[b];
         while (!in_ready) @(negedge clk);
         @(posedge clk);
      end
      k = 0;
      held = 1'b0;
      held_val = '0;
      while (k < NF) begin
         @(negedge clk);
         // Junk offered on the input while results drain (R8)
         in_valid  = 1'b1;
         in_bin    = 32'hDEAD_0000 | 32'(k);
         out_ready = backpressure ? ($urandom % 3 != 0) : 1'b1;
         if (held && out_valid)
            check(out_loge == held_val, "R9 stall hold", out_loge, held_val);
         held = 1'b0;
         if (out_valid) begin
            check(in_ready == 1'b0, "R8 input closed", in_ready, 0);
            if (out_ready) begin
               check(longint'(out_loge) == exp_log[k], req, out_loge, exp_log[k]);
               check(out_last == (k == NF - 1), "R7 last flag", out_last, (k == NF - 1));
               k++;
            end else begin
               held = 1'b1;
               held_val = out_loge;
            end
         end
      end
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b0;
      check(in_ready == 1'b1 && out_valid == 1'b0, "R7 reopen", {in_ready, out_valid}, 2);
   endtask

   function automatic int unsigned next_rand();
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hA300_0001 : 32'h0);
      return lfsr;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      check(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
      check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: silent frame gives all-zero words
      for (int b = 0; b < NB; b++) frame[b] = '0;
      run_frame(1'b0, 1'b0, "R6 zero energy");

      // R10: full-scale frame, largest accumulations
      for (int b = 0; b < NB; b++) frame[b] = 32'hFFFF_FFFF;
      run_frame(1'b1, 1'b1, "R10 full scale");

      // R4: silent frame straight after full scale must not inherit energy
      for (int b = 0; b < NB; b++) frame[b] = '0;
      run_frame(1'b0, 1'b1, "R4 frame clear");

      // R2 R3 R5: ramp and pseudo-random spectra
      for (int b = 0; b < NB; b++) frame[b] = 32'(b) * 32'd16_777_000;
      run_frame(1'b1, 1'b1, "R2 R3 R5 ramp");
      for (int r = 0; r < 3; r++) begin
         for (int b = 0; b < NB; b++) frame[b] = next_rand() >> (r * 9);
         run_frame(1'b1, 1'b1, "R2 R3 R5 random");
      end

      // R3 R2 R5: impulse at every bin position, including band edges
      for (int p = 0; p < NB; p++) begin
         for (int b = 0; b < NB; b++) frame[b] = '0;
         frame[p] = 32'hFFFF_FFFF - 32'(p) * 32'd9_999_991;
         run_frame(1'b0, (p % 4 == 0), "R3 R2 R5 impulse");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule